// File: doc/BRIEF.md
# Baud Divisor Register Pair with Staged High Byte

This block is a byte-wide register slave. It holds a 13-bit baud-rate modulo divisor and three control bits. The divisor is split across two byte registers. The high register also carries an enable for the line-break interrupt, an enable for the receive-line active-edge interrupt, and a select for the number of stop bits.

Software first writes the high register. The divisor bits of that write are parked in a staging buffer. The working divisor changes only when the low register is written, and then the staged bits and the new low byte load together. This means the tick generator never sees a divisor that mixes old and new halves.

The working divisor drives a modulo counter. The counter emits a one-cycle tick every divisor cycles, which the receiver uses as its 16x oversampling strobe. Two interrupt outputs pass the externally detected break and edge flags through their enables. The register bus is a plain single-cycle write strobe with combinational read data. It has no handshake, so it never applies back-pressure and never stalls.

Top module: `baud_div_regs`

## Requirements
- R1: After reset the high register (offset 0) reads 00h and the low register (offset 1) reads 04h. The first tick appears on the 4th rising edge after reset is released, and ticks repeat every 4 cycles.
- R2: A write to offset 0 does not change the working divisor. Bits 4:0 of a readback at offset 0 keep their old value, and the tick period keeps its old value.
- R3: A write to offset 1 loads the working divisor in one step. Divisor bits 12:8 come from the staged high bits and bits 7:0 come from the written byte. Offset 0 bits 4:0 then read divisor bits 12:8, and offset 1 reads divisor bits 7:0.
- R4: Bits 7, 6 and 5 of a write to offset 0 take effect on that write and read back at the same positions.
- R5: `brk_irq` is 1 exactly when offset-0 bit 7 is 1 and `brk_flag` is 1.
- R6: `edge_irq` is 1 exactly when offset-0 bit 6 is 1 and `edge_flag` is 1.
- R7: `two_stop` equals offset-0 bit 5. The value 0 selects one stop bit and the value 1 selects two.
- R8: While the working divisor is 0, `baud_tick` stays low.
- R9: With a nonzero divisor D, `baud_tick` pulses once every D cycles. Each pulse is one cycle wide when D is 2 or more, and the tick stays high when D is 1.
- R10: When a divisor commits, the counter restarts. The first tick appears on the D-th rising edge after the committing edge, and there is no tick in the cycle right after that edge.
- R11: A write to offset 1 with no new offset-0 write reuses the divisor bits most recently staged by an offset-0 write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Byte offset: 0 selects the high register, 1 selects the low register |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| brk_flag | input | 1 | Line-break detected flag from the receiver |
| edge_flag | input | 1 | Receive-line active-edge flag |
| brk_irq | output | 1 | Gated break interrupt request |
| edge_irq | output | 1 | Gated edge interrupt request |
| two_stop | output | 1 | Stop-bit count select: 1 means two stop bits |
| baud_tick | output | 1 | 16x oversampling tick |

## Verification
A corrupted working divisor shows at the ports in two ways. Readback of the high or low register changes at once, and the spacing of `baud_tick` changes on the very next period. A staging buffer that leaks early shows as a changed high-register readback right after an offset-0 write. A staging buffer that is lost shows as a wrong divisor after the following offset-1 write. A counter that fails to restart on commit shows as a first tick that arrives earlier or later than D edges after the commit, so the error is visible within one divisor period.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int BYTE_W      = 8;
  localparam int OFS_HI      = 0;
  localparam int OFS_LO      = 1;
  localparam int BIT_BRK_EN  = 7;
  localparam int BIT_EDGE_EN = 6;
  localparam int BIT_STOP2   = 5;
  localparam int N_IRQ       = 2;

  typedef struct packed {
    logic brk_en;
    logic edge_en;
    logic stop2;
  } ctrl_t;
endpackage

// File: rtl/baud_regfile.sv
module baud_regfile
  import baud_pkg::*;
#(
  parameter int DIV_W     = 13,
  parameter int ADDR_W    = 1,
  parameter int RESET_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output ctrl_t             ctrl_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              commit_o
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0]  stage_hi;
  logic [DIV_W-1:0] div_q;
  ctrl_t            ctrl_q;
  logic             wr_hi, wr_lo;
  logic [BYTE_W-1:0] rd_hi;

  assign wr_hi = wr && (addr == ADDR_W'(OFS_HI));
  assign wr_lo = wr && (addr == ADDR_W'(OFS_LO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= '0;
      ctrl_q   <= '0;
    end else if (wr_hi) begin
      stage_hi <= wdata[HI_W-1:0];
      ctrl_q   <= '{brk_en:  wdata[BIT_BRK_EN],
                    edge_en: wdata[BIT_EDGE_EN],
                    stop2:   wdata[BIT_STOP2]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= DIV_W'(RESET_DIV);
    else if (wr_lo) div_q <= {stage_hi, wdata};
  end

  always_comb begin
    rd_hi = '0;
    rd_hi[BIT_BRK_EN]  = ctrl_q.brk_en;
    rd_hi[BIT_EDGE_EN] = ctrl_q.edge_en;
    rd_hi[BIT_STOP2]   = ctrl_q.stop2;
    for (int i = 0; i < HI_W; i++) rd_hi[i] = div_q[BYTE_W+i];
  end

  always_comb begin
    if (addr == ADDR_W'(OFS_LO)) rdata = div_q[BYTE_W-1:0];
    else if (addr == ADDR_W'(OFS_HI)) rdata = rd_hi;
    else rdata = '0;
  end

  assign ctrl_o   = ctrl_q;
  assign div_o    = div_q;
  assign commit_o = wr_lo;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  localparam logic [DIV_W-1:0] CNT_START = DIV_W'(1);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= CNT_START;
      tick <= 1'b0;
    end else if (restart || div == '0) begin
      cnt  <= CNT_START;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= CNT_START;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_irq_gate.sv
module baud_irq_gate #(
  parameter int N = 2
) (
  input  logic [N-1:0] en,
  input  logic [N-1:0] flag,
  output logic [N-1:0] irq
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    assign irq[g] = en[g] & flag[g];
  end
endmodule

// File: rtl/baud_div_regs.sv
module baud_div_regs
  import baud_pkg::*;
#(
  parameter int DIV_W     = 13,
  parameter int ADDR_W    = 1,
  parameter int RESET_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              brk_flag,
  input  logic              edge_flag,
  output logic              brk_irq,
  output logic              edge_irq,
  output logic              two_stop,
  output logic              baud_tick
);
  ctrl_t             ctrl;
  logic [DIV_W-1:0]  div_act;
  logic              commit;
  logic [N_IRQ-1:0]  irq_vec;

  baud_regfile #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .RESET_DIV(RESET_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .ctrl_o(ctrl), .div_o(div_act), .commit_o(commit)
  );

  baud_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div_act), .restart(commit), .tick(baud_tick)
  );

  baud_irq_gate #(.N(N_IRQ)) u_irq (
    .en({ctrl.edge_en, ctrl.brk_en}),
    .flag({edge_flag, brk_flag}),
    .irq(irq_vec)
  );

  assign brk_irq  = irq_vec[0];
  assign edge_irq = irq_vec[1];
  assign two_stop = ctrl.stop2;
endmodule

// File: rtl/baud_div_chk.sv
module baud_div_chk #(
  parameter int DIV_W  = 13,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic              brk_flag,
  input logic              edge_flag,
  input logic              brk_irq,
  input logic              edge_irq,
  input logic              baud_tick,
  input logic [DIV_W-1:0]  div_act
);
  AST_HI_WRITE_HOLDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(0)) |=> $stable(div_act)); // R2
  AST_BRK_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> brk_flag); // R5
  AST_EDGE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    edge_irq |-> edge_flag); // R6
  AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (div_act == '0) |=> !baud_tick); // R8
  AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && div_act > DIV_W'(1)) |=> !baud_tick); // R9
  AST_COMMIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(1)) |=> !baud_tick); // R10
endmodule

bind baud_div_regs baud_div_chk #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .brk_flag(brk_flag), .edge_flag(edge_flag), .brk_irq(brk_irq),
  .edge_irq(edge_irq), .baud_tick(baud_tick), .div_act(div_act)
);

// File: tb/test_baud_div_regs.sv
module test_baud_div_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [0:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       brk_flag = 1'b0, edge_flag = 1'b0;
  logic       brk_irq, edge_irq, two_stop, baud_tick;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [12:0] m_div = 13'd4;
  logic [4:0]  m_stage = '0;
  logic [2:0]  m_ctrl = '0;

  always #4 clk = ~clk;

  baud_div_regs i_baud_div_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .brk_flag(brk_flag),
    .edge_flag(edge_flag), .brk_irq(brk_irq), .edge_irq(edge_irq),
    .two_stop(two_stop), .baud_tick(baud_tick)
  );

  function automatic logic [7:0] exp_hi();
    return {m_ctrl, m_div[12:8]};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a == 1'b0) begin
      m_stage = d[4:0];
      m_ctrl  = d[7:5];
    end else begin
      m_div = {m_stage, d};
    end
  endtask

  task automatic rd_reg(logic a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; #1;
    v = reg_rdata;
  endtask

  task automatic first_tick(string req, int exp);
    int n = 0;
    for (int i = 1; i <= 200; i++) begin
      @(posedge clk); #1;
      if (baud_tick) begin n = i; break; end
    end
    chk(req, n, exp);
  endtask

  task automatic tick_period(string req, int exp);
    int n = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (baud_tick) break;
    end
    for (int i = 1; i <= 200; i++) begin
      @(posedge clk); #1;
      if (baud_tick) begin n = i; break; end
    end
    chk(req, n, exp);
  endtask

  task automatic check_readback(string req);
    logic [7:0] v;
    rd_reg(1'b0, v); chk(req, v, exp_hi());
    rd_reg(1'b1, v); chk(req, v, m_div[7:0]);
    chk({req, " stop"}, two_stop, m_ctrl[0]);
  endtask

  task automatic check_irq();
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      brk_flag = f[0]; edge_flag = f[1]; #1;
      chk("R5 brk_irq", brk_irq, m_ctrl[2] & f[0]);
      chk("R6 edge_irq", edge_irq, m_ctrl[1] & f[1]);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cnt;
    void'($urandom(32'd20240917));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    reg_addr = 1'b0; #1; chk("R1 hi reset", reg_rdata, 8'h00);
    reg_addr = 1'b1; #1; chk("R1 lo reset", reg_rdata, 8'h04);
    first_tick("R1 first tick", 4);
    tick_period("R1 period", 4);

    // R3 / R10: commit a small divisor, first tick D edges later
    wr_reg(1'b0, 8'h00); wr_reg(1'b1, 8'd7);
    first_tick("R10 restart", 7);
    tick_period("R9 period 7", 7);
    check_readback("R3");

    // R2: staged high bits stay invisible, period unchanged
    wr_reg(1'b0, 8'h1F);
    rd_reg(1'b0, v); chk("R2 hi hold", v[4:0], 5'd0);
    tick_period("R2 period kept", 7);

    // R11: low write reuses staged high bits
    wr_reg(1'b1, 8'h12); check_readback("R11 a");
    wr_reg(1'b1, 8'h34); check_readback("R11 b");
    rd_reg(1'b0, v); chk("R11 hi", v[4:0], 5'h1F);

    // R8: zero divisor stops ticks
    wr_reg(1'b0, 8'h00); wr_reg(1'b1, 8'h00);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin @(posedge clk); #1; cnt += baud_tick; end
    chk("R8 no tick", cnt, 0);

    // R9: divisor 1 keeps tick high
    wr_reg(1'b1, 8'h01);
    first_tick("R9 div1 first", 1);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin @(posedge clk); #1; cnt += baud_tick; end
    chk("R9 div1 steady", cnt, 10);

    // R4 R5 R6 R7: control bits act at once
    for (int c = 0; c < 8; c++) begin
      wr_reg(1'b0, {c[2:0], 5'd0});
      rd_reg(1'b0, v); chk("R4 ctrl", v[7:5], c);
      chk("R7 two_stop", two_stop, c[0]);
      check_irq();
    end

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [12:0] d;
      logic [2:0]  c;
      c = 3'($urandom);
      if (it % 2 == 0) d = 13'($urandom_range(2, 30));
      else d = 13'($urandom_range(0, 8191));
      wr_reg(1'b0, {c, d[12:8]});
      rd_reg(1'b0, v); chk("R2 rand hold", v, {c, m_div[12:8]});
      wr_reg(1'b1, d[7:0]);
      if (d >= 2 && d <= 30) begin
        first_tick("R10 rand", d);
        tick_period("R9 rand", d);
      end
      check_readback("R3 rand");
      check_irq();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule